// File: doc/BRIEF.md
# NAND flash host controller

This block lets a processor drive a raw 8-bit NAND flash bus through a small set of 32-bit registers. Writing the command register or the address register emits a single latch cycle, with CLE or ALE raised. A 32-bit access to the data port expands into four byte strobes, most significant byte first. A control register steers one of up to four active-low chip enables, or releases all of them. It also fires a one-cycle clear pulse to an external ECC accumulator. Each chip select has its own timing register. The low field of that register sets how long WE# or RE# stays low, and the same count sets the high time that follows.

The register side is a valid/ready request channel with word addressing. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_addr`, `req_write` and `req_wdata` stable while `req_valid` is high and `req_ready` is low. Read data on `req_rdata` is valid in the same cycle as the handshake. A data-port read holds `req_ready` low until four bytes have been gathered. A data-port, command or address write is taken at once, and `req_ready` then stays low while its byte cycles run. The flash ready/busy line passes through a two-flop synchronizer before it reaches the status register.

Register word addresses are: 0 control, 1 command, 2 address, 3 status, 4 data port, and 8+n for the timing register of chip select n.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset every chip enable is high (inactive), WE# and RE# are high, CLE and ALE are low, and the control register reads 0x4: bank field 0 and release flag set.
- R2: Writing the control register with bit 2 clear and bank field bits [1:0] = n drives `nand_ce_n[n]` low and every other chip enable high. The control register then reads back n in bits [1:0].
- R3: Writing the control register with bit 2 set drives every chip enable high from the next cycle, and bit 2 reads back as 1.
- R4: A command-register write emits exactly one WE# pulse with CLE high, ALE low and `nand_dq_o` equal to bits [7:0] of the written word.
- R5: An address-register write emits exactly one WE# pulse with ALE high, CLE low and `nand_dq_o` equal to bits [7:0] of the written word.
- R6: A data-port write emits four WE# pulses with CLE and ALE low, carrying bits [31:24], [23:16], [15:8] and then [7:0] of the word.
- R7: A data-port read emits four RE# pulses with the data bus not driven. The bytes sampled at the end of each low phase are returned as one word with the first byte in bits [31:24]. `req_ready` stays low until the fourth byte is taken.
- R8: Each WE#/RE# low phase lasts P clocks, and the high phase between strobes of one access also lasts P clocks. P is bits [3:0] of the selected bank's timing register, and a value of 0 counts as 1.
- R9: The timing register of chip select n sits at word address 8+n, resets to 2, and reads back the full 32-bit value written.
- R10: Status bit 0 shows `nand_rb` after two clock edges through a synchronizer; after only one edge it still shows the old value.
- R11: Writing the control register with bit 3 set raises `ecc_clr` for exactly one cycle. Bit 3 always reads back as 0.
- R12: While byte cycles run, `req_ready` is low for every request, and the command, address and data strobes never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (4) | Register word address |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid during the handshake |
| nand_ce_n | output | NUM_CS (4) | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Flash data bus out |
| nand_dq_oe | output | 1 | Flash data bus drive enable |
| nand_dq_i | input | 8 | Flash data bus in |
| nand_rb | input | 1 | Flash ready/busy (1 = ready) |
| ecc_clr | output | 1 | One-cycle ECC accumulator clear |

## Verification
The assertions check on every cycle the properties that hold at any time: at most one chip enable is active, CLE and ALE are never both high, and WE# and RE# never overlap. They also check that the data bus is released during a read strobe, that it holds steady through a write strobe, that `req_ready` is low while the sequencer is busy, and that a release write leaves every chip enable high. The bench scenarios cover what needs a model of the flash side. That includes the byte order of gathered and scattered words, strobe widths per bank and the clamp of zero to one, and the two-edge delay of the ready flag. It also includes the timing-register readback and the single-cycle width of the ECC clear pulse.

// File: rtl/nhc_pkg.sv
package nhc_pkg;
  localparam int REG_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_WORD = REG_W / BYTE_W;

  localparam int A_CTL  = 0;
  localparam int A_CMD  = 1;
  localparam int A_ADR  = 2;
  localparam int A_STAT = 3;
  localparam int A_DATA = 4;
  localparam int A_CFG  = 8;

  localparam int CTL_REL_BIT = 2;
  localparam int CTL_ECC_BIT = 3;

  typedef enum logic [1:0] {
    K_CMD = 2'd0,
    K_ADR = 2'd1,
    K_WR  = 2'd2,
    K_RD  = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOW  = 2'd1,
    S_HIGH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/nhc_sync.sv
module nhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nhc_regs.sv
module nhc_regs
  import nhc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW = 4,
  parameter int CFG_RESET = 2,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [REG_W-1:0]             wdata,
  output logic [CSW-1:0]               bank,
  output logic                         ce_off,
  output logic                         ecc_pulse,
  output logic [NUM_CS-1:0][REG_W-1:0] cfg
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == AW'(A_CTL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank      <= '0;
      ce_off    <= 1'b1;
      ecc_pulse <= 1'b0;
    end else begin
      ecc_pulse <= ctl_wr && wdata[CTL_ECC_BIT];
      if (ctl_wr) begin
        bank   <= wdata[CSW-1:0];
        ce_off <= wdata[CTL_REL_BIT];
      end
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[i] <= REG_W'(CFG_RESET);
      else if (wr_en && (addr == AW'(A_CFG + i)))
        cfg[i] <= wdata;
    end
  end
endmodule

// File: rtl/nhc_seq.sv
module nhc_seq
  import nhc_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cyc_kind_e         kind_i,
  input  logic [REG_W-1:0]  wdata,
  input  logic [TW-1:0]     pulse,
  input  logic [BYTE_W-1:0] dq_i,
  output logic              busy,
  output logic              done,
  output cyc_kind_e         kind_o,
  output logic [REG_W-1:0]  word_o,
  output logic              we_n,
  output logic              re_n,
  output logic              cle,
  output logic              ale,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int NBW = $clog2(BYTES_PER_WORD);

  seq_state_e        st;
  cyc_kind_e         kind;
  logic [TW-1:0]     tmr;
  logic [TW-1:0]     plen;
  logic [NBW-1:0]    left;
  logic [REG_W-1:0]  sh;
  logic              is_data;

  assign is_data = (kind_i == K_WR) || (kind_i == K_RD);
  assign done    = (st == S_HIGH) && (tmr == '0) && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      kind <= K_CMD;
      tmr  <= '0;
      plen <= '0;
      left <= '0;
      sh   <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            st   <= S_LOW;
            kind <= kind_i;
            plen <= pulse;
            tmr  <= pulse - TW'(1);
            left <= is_data ? NBW'(BYTES_PER_WORD - 1) : '0;
            sh   <= is_data ? wdata : {wdata[BYTE_W-1:0], {(REG_W-BYTE_W){1'b0}}};
          end
        end
        S_LOW: begin
          if (tmr == '0) begin
            st  <= S_HIGH;
            tmr <= plen - TW'(1);
            if (kind == K_RD) sh <= {sh[REG_W-BYTE_W-1:0], dq_i};
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        S_HIGH: begin
          if (tmr == '0) begin
            if (left == '0) begin
              st <= S_IDLE;
            end else begin
              st   <= S_LOW;
              left <= left - NBW'(1);
              tmr  <= plen - TW'(1);
              if (kind != K_RD) sh <= {sh[REG_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
            end
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign kind_o = kind;
  assign word_o = sh;
  assign we_n   = !((st == S_LOW) && (kind != K_RD));
  assign re_n   = !((st == S_LOW) && (kind == K_RD));
  assign cle    = busy && (kind == K_CMD);
  assign ale    = busy && (kind == K_ADR);
  assign dq_oe  = busy && (kind != K_RD);
  assign dq_o   = dq_oe ? sh[REG_W-1 -: BYTE_W] : '0;
endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nhc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW = 4,
  parameter int TW = 4,
  parameter int CFG_RESET = 2,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic [REG_W-1:0]  req_rdata,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BYTE_W-1:0] nand_dq_o,
  output logic              nand_dq_oe,
  input  logic [BYTE_W-1:0] nand_dq_i,
  input  logic              nand_rb,
  output logic              ecc_clr
);
  logic                         seq_busy, seq_done, seq_start;
  cyc_kind_e                    seq_kind_q, start_kind;
  logic [REG_W-1:0]             seq_word;
  logic [CSW-1:0]               bank;
  logic                         ce_off, rb_s, rd_done;
  logic [NUM_CS-1:0][REG_W-1:0] cfg;
  logic [TW-1:0]                pulse_raw, pulse;
  logic                         at_data_rd, acc, wr_acc, wr_start, rd_start;

  assign at_data_rd = !req_write && (req_addr == AW'(A_DATA));
  assign req_ready  = !seq_busy && (!at_data_rd || rd_done);
  assign acc        = req_valid && req_ready;
  assign wr_acc     = acc && req_write;
  assign wr_start   = wr_acc && ((req_addr == AW'(A_CMD)) ||
                                 (req_addr == AW'(A_ADR)) ||
                                 (req_addr == AW'(A_DATA)));
  assign rd_start   = req_valid && at_data_rd && !seq_busy && !rd_done;
  assign seq_start  = wr_start || rd_start;

  always_comb begin
    start_kind = K_RD;
    if (req_write) begin
      if (req_addr == AW'(A_CMD))      start_kind = K_CMD;
      else if (req_addr == AW'(A_ADR)) start_kind = K_ADR;
      else                             start_kind = K_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rd_done <= 1'b0;
    else if (seq_done && seq_kind_q == K_RD)  rd_done <= 1'b1;
    else if (acc && at_data_rd)               rd_done <= 1'b0;
  end

  nhc_regs #(.NUM_CS(NUM_CS), .AW(AW), .CFG_RESET(CFG_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(req_addr),
    .wdata(req_wdata), .bank(bank), .ce_off(ce_off),
    .ecc_pulse(ecc_clr), .cfg(cfg)
  );

  nhc_sync #(.STAGES(2)) u_rb_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_s)
  );

  assign pulse_raw = cfg[bank][TW-1:0];
  assign pulse     = (pulse_raw == '0) ? TW'(1) : pulse_raw;

  nhc_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .kind_i(start_kind),
    .wdata(req_wdata), .pulse(pulse), .dq_i(nand_dq_i),
    .busy(seq_busy), .done(seq_done), .kind_o(seq_kind_q), .word_o(seq_word),
    .we_n(nand_we_n), .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    assign nand_ce_n[i] = ce_off || (bank != CSW'(i));
  end

  always_comb begin
    req_rdata = '0;
    if (req_addr == AW'(A_CTL))
      req_rdata = {{(REG_W-3){1'b0}}, ce_off, 2'(bank)};
    else if (req_addr == AW'(A_STAT))
      req_rdata = {{(REG_W-1){1'b0}}, rb_s};
    else if (req_addr == AW'(A_DATA))
      req_rdata = seq_word;
    for (int i = 0; i < NUM_CS; i++)
      if (req_addr == AW'(A_CFG + i)) req_rdata = cfg[i];
  end
endmodule

// File: rtl/nhc_chk.sv
module nhc_chk
  import nhc_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic [REG_W-1:0]  req_wdata,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic [BYTE_W-1:0] nand_dq_o,
  input logic              nand_dq_oe,
  input logic              seq_busy
);
  a_r2_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  a_r3_release_all: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == AW'(A_CTL) &&
     req_wdata[CTL_REL_BIT]) |=> (&nand_ce_n));

  a_r5_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r12_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> !req_ready);

  a_r7_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  a_r6_dq_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));
endmodule

bind nand_host_ctrl nhc_chk #(.NUM_CS(NUM_CS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
  .nand_dq_oe(nand_dq_oe), .seq_busy(seq_busy)
);

// File: tb/tb_nand_host_ctrl.sv
module tb_nand_host_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic        req_ready;
  logic [3:0]  req_addr = 0;
  logic [31:0] req_wdata = 0, req_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, ecc_clr;
  logic [7:0]  nand_dq_o, nand_dq_i = 0;
  logic        nand_rb = 1;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  nand_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb(nand_rb), .ecc_clr(ecc_clr)
  );

  // flash-side monitor, sampled on falling edges
  logic [7:0] cap_b [16];
  logic       cap_c [16];
  logic       cap_a [16];
  int         n_cap = 0, n_re = 0, low_w = 0, last_low = 0, hi_cnt = 0, last_gap = 0;
  int         ecc_cycles = 0;
  logic [7:0] rd_q [4];
  logic       p_we = 1, p_re = 1;

  always @(negedge clk) begin
    if (ecc_clr) ecc_cycles++;
    if (!nand_we_n || !nand_re_n) low_w++;
    else hi_cnt++;
    if ((p_we && !nand_we_n) || (p_re && !nand_re_n)) begin
      last_gap = hi_cnt;
      hi_cnt = 0;
    end
    if (p_re && !nand_re_n) begin
      nand_dq_i = rd_q[n_re % 4];
      n_re++;
    end
    if ((!p_we && nand_we_n) || (!p_re && nand_re_n)) begin
      last_low = low_w;
      low_w = 0;
      hi_cnt = 1;
    end
    if (!p_we && nand_we_n && n_cap < 16) begin
      cap_b[n_cap] = nand_dq_o;
      cap_c[n_cap] = nand_cle;
      cap_a[n_cap] = nand_ale;
      n_cap++;
    end
    p_we = nand_we_n;
    p_re = nand_re_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #0.5;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #0.5 req_valid = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d, output int waited);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    waited = 0;
    #0.5;
    while (!req_ready) begin @(negedge clk); waited++; end
    d = req_rdata;
    @(posedge clk);
    #0.5 req_valid = 0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; int w;
    chk("R1 ce_n", 32'(nand_ce_n), 32'hF);
    chk("R1 strobes", {28'b0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hC);
    reg_rd(0, d, w);
    chk("R1 ctl", d, 32'h4);
  endtask

  task automatic t_bank_ce();
    logic [31:0] d; int w;
    for (int b = 0; b < 4; b++) begin
      reg_wr(0, 32'(b));
      @(negedge clk);
      chk("R2 ce_n", 32'(nand_ce_n), 32'(~(4'b1 << b) & 4'hF));
      reg_rd(0, d, w);
      chk("R2 ctl", d, 32'(b));
    end
  endtask

  task automatic t_release();
    logic [31:0] d; int w;
    reg_wr(0, 32'h6);
    @(negedge clk);
    chk("R3 ce_n", 32'(nand_ce_n), 32'hF);
    reg_rd(0, d, w);
    chk("R3 ctl", d, 32'h6);
    reg_wr(0, 32'h1);
  endtask

  task automatic t_cmd_addr();
    n_cap = 0;
    reg_wr(1, 32'h1234_5670);
    idle_wait(8);
    chk("R4 count", 32'(n_cap), 1);
    chk("R4 byte", {cap_c[0], cap_a[0], 22'b0, cap_b[0]}, {1'b1, 1'b0, 22'b0, 8'h70});
    chk("R8 low width", 32'(last_low), 2);
    n_cap = 0;
    reg_wr(2, 32'hFFFF_FFA5);
    idle_wait(8);
    chk("R5 count", 32'(n_cap), 1);
    chk("R5 byte", {cap_c[0], cap_a[0], 22'b0, cap_b[0]}, {1'b0, 1'b1, 22'b0, 8'hA5});
  endtask

  task automatic t_data_wr();
    logic [31:0] d; int w;
    n_cap = 0;
    reg_wr(4, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R12 ready low", 32'(req_ready), 0);
    reg_rd(3, d, w);
    chk("R12 stall", 32'(w >= 12 && w <= 17), 1);
    idle_wait(4);
    chk("R6 count", 32'(n_cap), 4);
    chk("R6 bytes", {cap_b[0], cap_b[1], cap_b[2], cap_b[3]}, 32'hDEAD_BEEF);
    chk("R6 latches", 32'({cap_c[0], cap_c[3], cap_a[0], cap_a[3]}), 0);
    chk("R8 gap", 32'(last_gap), 2);
  endtask

  task automatic t_data_rd();
    logic [31:0] d; int w;
    rd_q[0] = 8'hA1; rd_q[1] = 8'hB2; rd_q[2] = 8'hC3; rd_q[3] = 8'hD4;
    n_re = 0;
    reg_rd(4, d, w);
    chk("R7 word", d, 32'hA1B2_C3D4);
    chk("R7 strobes", 32'(n_re), 4);
    chk("R7 stalled", 32'(w >= 15), 1);
  endtask

  task automatic t_timing();
    logic [31:0] d; int w;
    reg_wr(4'd10, 32'hCAFE_0003);
    reg_rd(4'd10, d, w);
    chk("R9 readback", d, 32'hCAFE_0003);
    reg_rd(4'd9, d, w);
    chk("R9 reset value", d, 32'h2);
    reg_wr(0, 32'h2);
    n_cap = 0;
    reg_wr(4, 32'h0102_0304);
    idle_wait(30);
    chk("R8 low P3", 32'(last_low), 3);
    chk("R8 gap P3", 32'(last_gap), 3);
    chk("R6 bytes P3", {cap_b[0], cap_b[1], cap_b[2], cap_b[3]}, 32'h0102_0304);
    reg_wr(4'd11, 32'h0);
    reg_wr(0, 32'h3);
    reg_wr(1, 32'h55);
    idle_wait(6);
    chk("R8 zero as one", 32'(last_low), 1);
    reg_wr(0, 32'h1);
  endtask

  task automatic t_status();
    logic [31:0] d; int w;
    reg_rd(3, d, w);
    chk("R10 ready", d, 1);
    @(negedge clk);
    nand_rb = 0;
    @(posedge clk); #0.5;
    req_valid = 0; req_addr = 3; req_write = 0;
    #0.5 chk("R10 one edge", req_rdata, 1);
    @(posedge clk); #1;
    chk("R10 two edges", req_rdata, 0);
    nand_rb = 1;
  endtask

  task automatic t_ecc();
    logic [31:0] d; int w;
    ecc_cycles = 0;
    reg_wr(0, 32'h9);
    idle_wait(4);
    chk("R11 pulse", 32'(ecc_cycles), 1);
    reg_rd(0, d, w);
    chk("R11 readback", d, 32'h1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_reset();
        t_bank_ce();
        t_release();
        t_cmd_addr();
        t_data_wr();
        t_data_rd();
        t_timing();
        t_status();
        t_ecc();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule